// File: doc/BRIEF.md
# Debug Link Acknowledge Pulse Generator

This block sits on the target end of a single-wire, open-drain background debug link. When the serial front end signals that the last bit of a command has ended, the block begins a wait. It drives the shared line only after two conditions are both true. First, a minimum number of link-clock cycles must have passed since the command ended. Second, the CPU-side execution logic must have reported that the command has finished. The acknowledge is a fixed-length low pulse. It is followed by a single cycle of active-high drive that speeds up the line's return to high, and then the line is released.

The wait has no upper bound, so a slow CPU only delays the acknowledge. If the CPU enters stop mode before a pending command has executed, the command is dropped and no acknowledge is sent. A 3-bit status field then records the drop. It holds that value until a later command completes.

Top module: `dbg_ack_pulser`

## Requirements
- R1: While `rst_ni` is low and after it is released, `line_oe_o` is 0 and `status_o` is 000, with no command pending.
- R2: When completion arrives early, the low pulse starts (`line_oe_o`=1, `line_val_o`=0 visible) right after the clock edge that is `MIN_DLY` (32) edges after the edge that sampled `cmd_end_i`. It never starts earlier.
- R3: When `exec_done_i` is sampled on edge d, with d at or beyond the minimum, the low pulse starts right after edge d. There is no upper limit on d.
- R4: No acknowledge is driven for a pending command until `exec_done_i` has been seen.
- R5: The low pulse lasts exactly `LOW_LEN` (16) cycles with `line_oe_o`=1 and `line_val_o`=0.
- R6: Right after the low pulse, the line is driven high (`line_oe_o`=1, `line_val_o`=1) for one cycle. From the next cycle `line_oe_o` is 0.
- R7: A `stop_i` sampled while a command waits and before any completion drops the command. No pulse follows, and `status_o` becomes 001.
- R8: A `stop_i` sampled after completion has been latched has no effect, and the acknowledge follows as in R2.
- R9: `status_o` keeps 001 until an acknowledge starts, and then becomes 000. Encoding: 000 means no drop recorded, 001 means the last command was dropped by stop mode.
- R10: A `cmd_end_i` that arrives while a command is pending or the line is being driven is ignored. The timing of the current acknowledge is unchanged and no second pulse follows.
- R11: An `exec_done_i` that arrives with no command pending is ignored, and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_end_i | input | 1 | Strobe on the 16th link cycle of the last command bit |
| exec_done_i | input | 1 | Strobe from CPU side: command executed |
| stop_i | input | 1 | CPU has entered stop mode |
| line_oe_o | output | 1 | Drive enable for the open-drain line |
| line_val_o | output | 1 | Value driven when enabled |
| status_o | output | 3 | Command status: 000 none, 001 dropped by stop |

## Verification
The assertions assume that `exec_done_i` and `cmd_end_i` are single-cycle strobes. They also assume that completion is reported only for a command the front end actually issued, and that `stop_i` is a level or pulse that the block samples on clock edges. The stimulus drives every strobe for exactly one edge from the falling clock edge. It raises completion only after the command-end edge, except in the one case that deliberately probes R11 with the block idle. Stop is asserted either before any completion or after a latched completion, so the intent of each case is unambiguous.

// File: rtl/ack_pkg.sv
`timescale 1ns/1ps
package ack_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_LOW  = 2'd2,
    S_SPD  = 2'd3
  } ack_st_e;

  localparam logic [2:0] STAT_NONE    = 3'b000;
  localparam logic [2:0] STAT_DROPPED = 3'b001;
endpackage

// File: rtl/ack_cnt.sv
`timescale 1ns/1ps
module ack_cnt #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !hit_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == lim_i);
endmodule

// File: rtl/ack_fsm.sv
`timescale 1ns/1ps
module ack_fsm
  import ack_pkg::*;
#(
  parameter int MIN_DLY = 32,
  parameter int LOW_LEN = 16,
  parameter int CNT_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_end_i,
  input  logic             exec_done_i,
  input  logic             stop_i,
  input  logic             cnt_hit_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic [CNT_W-1:0] cnt_lim_o,
  output logic             start_o,
  output logic             drop_o,
  output ack_st_e          st_o
);
  localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(MIN_DLY - 1);
  localparam logic [CNT_W-1:0] LOW_LIM  = CNT_W'(LOW_LEN - 1);

  ack_st_e st_q, st_d;
  logic    done_q;
  logic    done_any;

  assign done_any = done_q || exec_done_i;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    drop_o  = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_end_i) st_d = S_WAIT;
      S_WAIT: begin
        if (done_any && cnt_hit_i) begin
          st_d    = S_LOW;
          start_o = 1'b1;
        end else if (stop_i && !done_any) begin
          // stop before execution: command discarded silently
          st_d   = S_IDLE;
          drop_o = 1'b1;
        end
      end
      S_LOW:  if (cnt_hit_i) st_d = S_SPD;
      S_SPD:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign cnt_clr_o = (st_q == S_IDLE) || (st_q == S_SPD) || start_o;
  assign cnt_en_o  = (st_q == S_WAIT) || (st_q == S_LOW);
  assign cnt_lim_o = (st_q == S_LOW) ? LOW_LIM : WAIT_LIM;
  assign st_o      = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == S_WAIT) && (st_d == S_WAIT) && done_any;
    end
  end

  assert_start_after_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT && st_d == S_LOW) |-> cnt_hit_i);

  assert_no_ack_without_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT && !done_q && !exec_done_i) |=> (st_q != S_LOW));

  assert_speedup_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SPD) |=> (st_q == S_IDLE));

  assert_retrigger_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_IDLE && cmd_end_i) |=> (st_q != S_WAIT || $past(st_q) == S_WAIT));
endmodule

// File: rtl/dbg_ack_pulser.sv
`timescale 1ns/1ps
module dbg_ack_pulser
  import ack_pkg::*;
#(
  parameter int MIN_DLY = 32,
  parameter int LOW_LEN = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_end_i,
  input  logic       exec_done_i,
  input  logic       stop_i,
  output logic       line_oe_o,
  output logic       line_val_o,
  output logic [2:0] status_o
);
  localparam int MAXC  = (MIN_DLY > LOW_LEN) ? MIN_DLY : LOW_LEN;
  localparam int CNT_W = (MAXC > 2) ? $clog2(MAXC) : 1;

  logic             cnt_clr, cnt_en, cnt_hit, start, drop;
  logic [CNT_W-1:0] cnt_lim;
  ack_st_e          st;
  logic [2:0]       status_q;

  ack_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .lim_i  (cnt_lim),
    .hit_o  (cnt_hit)
  );

  ack_fsm #(.MIN_DLY(MIN_DLY), .LOW_LEN(LOW_LEN), .CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_end_i   (cmd_end_i),
    .exec_done_i (exec_done_i),
    .stop_i      (stop_i),
    .cnt_hit_i   (cnt_hit),
    .cnt_clr_o   (cnt_clr),
    .cnt_en_o    (cnt_en),
    .cnt_lim_o   (cnt_lim),
    .start_o     (start),
    .drop_o      (drop),
    .st_o        (st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= STAT_NONE;
    else if (drop)  status_q <= STAT_DROPPED;
    else if (start) status_q <= STAT_NONE;
  end

  assign line_oe_o  = (st == S_LOW) || (st == S_SPD);
  assign line_val_o = (st == S_SPD);
  assign status_o   = status_q;

  assert_low_followed_by_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_oe_o && !line_val_o) |=> line_oe_o);

  assert_drop_is_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q == STAT_DROPPED && $past(status_q) != STAT_DROPPED) |-> !line_oe_o);

  assert_high_then_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_oe_o && line_val_o) |=> !line_oe_o);
endmodule

// File: tb/dbg_ack_pulser_test.sv
`timescale 1ns/1ps
module dbg_ack_pulser_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_end = 1'b0, exec_done = 1'b0, stop = 1'b0;
  logic       line_oe, line_val;
  logic [2:0] status;
  int checks = 0, errors = 0;
  logic [2:0] stat_exp = 3'b000;

  always #4 clk = ~clk;

  dbg_ack_pulser uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_end_i(cmd_end), .exec_done_i(exec_done),
    .stop_i(stop), .line_oe_o(line_oe), .line_val_o(line_val), .status_o(status)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // k = 0 is the edge sampling cmd_end; exp_start < 0 means no pulse expected
  task automatic run_case(string tag, int done_at, int stop_at, int extra_at,
                          int exp_start, int horizon);
    logic [2:0] s_prev = stat_exp;
    for (int k = 0; k <= horizon; k++) begin
      cmd_end   = (k == 0) || (k == extra_at);
      exec_done = (k == done_at);
      stop      = (k == stop_at);
      @(posedge clk);
      @(negedge clk);
      cmd_end = 1'b0; exec_done = 1'b0; stop = 1'b0;
      if (exp_start >= 0 && k >= exp_start) stat_exp = 3'b000;
      else if (exp_start < 0 && stop_at >= 0 && k >= stop_at) stat_exp = 3'b001;
      else stat_exp = s_prev;
      if (exp_start >= 0 && k >= exp_start && k < exp_start + 16) begin
        chk({tag, " R5"}, "low oe", int'(line_oe), 1);
        chk({tag, " R5"}, "low val", int'(line_val), 0);
      end else if (exp_start >= 0 && k == exp_start + 16) begin
        chk({tag, " R6"}, "spd oe", int'(line_oe), 1);
        chk({tag, " R6"}, "spd val", int'(line_val), 1);
      end else begin
        chk(tag, "released oe", int'(line_oe), 0);
      end
      chk({tag, " R9"}, "status", int'(status), int'(stat_exp));
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "oe in reset", int'(line_oe), 0);
    chk("R1", "status in reset", int'(status), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "oe after reset", int'(line_oe), 0);
    chk("R1", "status after reset", int'(status), 0);
    stat_exp = 3'b000;
  endtask

  task automatic t_idle_done();
    exec_done = 1'b1;
    @(posedge clk); @(negedge clk);
    exec_done = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      chk("R11", "idle done oe", int'(line_oe), 0);
    end
  endtask

  task automatic t_reset_mid_pulse();
    run_case("R2", 3, -1, -1, 32, 36);  // ends inside the low pulse
    #1 rst_ni = 1'b0;
    #1 chk("R1", "oe on async reset", int'(line_oe), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    stat_exp = 3'b000;
    repeat (30) begin
      @(negedge clk);
      chk("R1", "oe after mid reset", int'(line_oe), 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    run_case("R2 early", 5, -1, -1, 32, 60);
    run_case("R2 R3 at min", 32, -1, -1, 32, 60);
    run_case("R3 late", 100, -1, -1, 100, 130);
    run_case("R3 R4 very late", 3000, -1, -1, 3000, 3030);
    run_case("R7 R11 drop", 50, 10, -1, -1, 120);
    run_case("R9 recover", 8, -1, -1, 32, 60);
    run_case("R7 second drop", -1, 40, -1, -1, 80);
    run_case("R8 stop after done", 5, 10, -1, 32, 60);
    run_case("R10 retrigger wait", 5, -1, 20, 32, 80);
    run_case("R10 retrigger low", 40, -1, 45, 40, 100);
    t_idle_done();
    t_reset_mid_pulse();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule